// File: doc/BRIEF.md
# Fixed-Point Multiply-Accumulate Unit

This block multiplies two 32-bit fixed-point operands in a single cycle and can either deliver the product to a register-file write port or fold it into one of two local 80-bit result registers. The operands come from a 40-bit register-file read port, and the unit uses only the top 32 bits of each. Each operand is marked signed or unsigned on its own. One shared flag marks both operands, and so the result, as integer or fractional.

An opcode selects the operation. The multiply opcodes are plain multiply, multiply-add and multiply-subtract, and each may round its result. The other opcodes act on a result register without multiplying: round it, saturate it to 64 bits, or clear it. The register-file result is combinational, so a source location can also be the destination in the same cycle. Result-register updates take effect at the next rising clock edge.

Each result register has a 16-bit overflow field above two 32-bit words. A fractional result returns the upper word to the register file and an integer result returns the lower word.

Top module: `fxmac_unit`

## Requirements
- R1: While rst_n is low, and on the first cycle after it rises, both result registers read zero, `ovf` is 0 and `rf_we` is 0.
- R2: Operands are bits 39:8 of `x_word` and `y_word`. Bits 7:0 have no effect on any result.
- R3: For a plain multiply (opcode 1), the selected register is loaded with the exact product. An operand whose signed flag is 1 is read as two's complement and one whose flag is 0 as unsigned. The product is sign-extended to 80 bits.
- R4: When `frac_mode` is 1 and both signed flags are 1, the product is shifted left by one bit. For any other flag combination the product is not shifted.
- R5: Multiply-add (opcode 2) writes register + product and multiply-subtract (opcode 3) writes register − product. Both wrap modulo 2^80.
- R6: With `round_en`=1 and `frac_mode`=1, a multiply result is rounded to the nearest multiple of 2^32, with ties going to an even bit 32, and the low word is cleared. When `frac_mode`=0, `round_en` has no effect.
- R7: A multiply opcode with `to_rf`=1 raises `rf_we` in the same cycle and leaves both result registers unchanged. `rf_wdata[39:8]` carries bits 63:32 of the (rounded) result when fractional and bits 31:0 when integer, and `rf_wdata[7:0]` is zero. In every other case `rf_we` is 0.
- R8: The round opcode (4) applies the R6 rounding to the selected register when `frac_mode`=1 and leaves it unchanged when `frac_mode`=0.
- R9: The saturate opcode (5) uses `x_signed` to choose between signed and unsigned handling. Signed: when bits 79:63 are not all equal, the register becomes 0x7FFF_FFFF_FFFF_FFFF (if bit 79 is 0) or its sign-extended negation −2^63 (if bit 79 is 1). Unsigned: when bits 79:64 are not all zero, the register becomes 0 if bit 79 is 1 and 2^64−1 otherwise. `ovf` is 1 in the cycle after a clamping saturate and 0 after every other operation.
- R10: The clear opcode (6) zeroes the selected register and leaves the other register unchanged.
- R11: Opcodes 0 and 7 change no register, and the unselected register never changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| opcode | input | 3 | Operation code |
| x_word | input | 40 | X operand from the register file |
| y_word | input | 40 | Y operand from the register file |
| x_signed | input | 1 | X is two's complement; also selects signed saturation |
| y_signed | input | 1 | Y is two's complement |
| frac_mode | input | 1 | Operands and result are fractional |
| round_en | input | 1 | Round the multiply result |
| acc_sel | input | 1 | Result register select |
| to_rf | input | 1 | Send the multiply result to the register file |
| rf_we | output | 1 | Register-file write strobe |
| rf_wdata | output | 40 | Register-file write data |
| ovf | output | 1 | Last saturate clamped |
| mr_q | output | 160 | Both result registers, register 0 in bits 79:0 |

## Verification
The hardest states to reach are the ones where rounding and saturation change the value. An exact rounding tie needs a low word of exactly 0x8000_0000. A clamp needs an overflow field that is not a sign extension, which no single product can produce in unsigned mode. Directed sequences build these states. Integer multiplies by 1 and by 3 place a 0x8000_0000 low word under an even and an odd bit 32. The fractional product −1 × −1 pushes the signed range past its limit. Repeated unsigned multiply-adds of 0xFFFF_FFFF squared carry into the overflow field, and a multiply-subtract from zero makes the register negative. A long random phase then mixes every opcode and flag.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;
   typedef enum logic [2:0] {
      OP_NOP  = 3'd0,
      OP_MUL  = 3'd1,
      OP_MADD = 3'd2,
      OP_MSUB = 3'd3,
      OP_RND  = 3'd4,
      OP_SAT  = 3'd5,
      OP_CLR  = 3'd6,
      OP_RSV  = 3'd7
   } fxmac_op_e;
endpackage

// File: rtl/fxmac_prod.sv
module fxmac_prod #(
   parameter int OP_W  = 32,
   parameter int ACC_W = 80
) (
   input  logic [OP_W-1:0]  x_op,
   input  logic [OP_W-1:0]  y_op,
   input  logic             x_signed,
   input  logic             y_signed,
   input  logic             frac_mode,
   output logic [ACC_W-1:0] prod_o
);
   localparam int FULL_W = 2*OP_W + 2;
   localparam int PAD_W  = ACC_W - FULL_W;

   logic signed [OP_W:0]     x_ext;
   logic signed [OP_W:0]     y_ext;
   logic signed [FULL_W-1:0] full;
   logic [ACC_W-1:0]         wide;

   assign x_ext = {x_signed & x_op[OP_W-1], x_op};
   assign y_ext = {y_signed & y_op[OP_W-1], y_op};
   assign full  = FULL_W'(x_ext) * FULL_W'(y_ext);

   generate
      if (PAD_W > 0) begin : g_pad
         assign wide = {{PAD_W{full[FULL_W-1]}}, full};
      end else begin : g_nopad
         assign wide = full[ACC_W-1:0];
      end
   endgenerate

   // a signed fractional product carries two sign bits; drop one
   assign prod_o = (frac_mode && x_signed && y_signed) ? (wide << 1) : wide;
endmodule

// File: rtl/fxmac_round.sv
module fxmac_round #(
   parameter int OP_W  = 32,
   parameter int ACC_W = 80
) (
   input  logic [ACC_W-1:0] val_i,
   input  logic             en_i,
   output logic [ACC_W-1:0] val_o
);
   localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (OP_W-1);
   localparam logic [ACC_W-1:0] KEEP = ~((ACC_W'(1) << OP_W) - ACC_W'(1));

   logic             tie;
   logic [ACC_W-1:0] bumped;

   assign tie    = (val_i[OP_W-1:0] == {1'b1, {(OP_W-1){1'b0}}});
   assign bumped = (tie && !val_i[OP_W]) ? val_i : (val_i + HALF);
   assign val_o  = en_i ? (bumped & KEEP) : val_i;
endmodule

// File: rtl/fxmac_sat.sv
module fxmac_sat #(
   parameter int OP_W  = 32,
   parameter int ACC_W = 80
) (
   input  logic [ACC_W-1:0] val_i,
   input  logic             signed_i,
   output logic [ACC_W-1:0] val_o,
   output logic             hit_o
);
   localparam int WORD2 = 2*OP_W;
   localparam int TOP_W = ACC_W - WORD2;
   localparam logic [ACC_W-1:0] SMAX = (ACC_W'(1) << (WORD2-1)) - ACC_W'(1);
   localparam logic [ACC_W-1:0] UMAX = (ACC_W'(1) << WORD2) - ACC_W'(1);

   logic [TOP_W:0]   s_field;
   logic [TOP_W-1:0] u_field;
   logic             s_hit;
   logic             u_hit;

   assign s_field = val_i[ACC_W-1:WORD2-1];
   assign u_field = val_i[ACC_W-1:WORD2];
   assign s_hit   = !((&s_field) || !(|s_field));
   assign u_hit   = |u_field;

   always_comb begin
      val_o = val_i;
      hit_o = 1'b0;
      if (signed_i) begin
         hit_o = s_hit;
         if (s_hit) val_o = val_i[ACC_W-1] ? ~SMAX : SMAX;
      end else begin
         hit_o = u_hit;
         if (u_hit) val_o = val_i[ACC_W-1] ? '0 : UMAX;
      end
   end
endmodule

// File: rtl/fxmac_unit.sv
module fxmac_unit
   import fxmac_pkg::*;
#(
   parameter int OP_W    = 32,
   parameter int RF_W    = 40,
   parameter int ACC_W   = 80,
   parameter int NUM_ACC = 2,
   localparam int SEL_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [2:0]               opcode,
   input  logic [RF_W-1:0]          x_word,
   input  logic [RF_W-1:0]          y_word,
   input  logic                     x_signed,
   input  logic                     y_signed,
   input  logic                     frac_mode,
   input  logic                     round_en,
   input  logic [SEL_W-1:0]         acc_sel,
   input  logic                     to_rf,
   output logic                     rf_we,
   output logic [RF_W-1:0]          rf_wdata,
   output logic                     ovf,
   output logic [NUM_ACC*ACC_W-1:0] mr_q
);
   localparam int PAD_RF = RF_W - OP_W;

   generate
      if (ACC_W < 2*OP_W + 2) begin : g_bad_acc
         $error("ACC_W must hold a full product plus guard bits");
      end
      if (RF_W < OP_W) begin : g_bad_rf
         $error("RF_W must be at least OP_W");
      end
      if (NUM_ACC < 2) begin : g_bad_num
         $error("NUM_ACC must be at least 2");
      end
   endgenerate

   fxmac_op_e        op;
   logic [OP_W-1:0]  x_op, y_op;
   logic [ACC_W-1:0] prod, mr_cur, acc_sum, rnd_val, sat_val, wr_val;
   logic             is_mul, rnd_en, sat_hit, wr_en;
   logic [OP_W-1:0]  rf_word;
   logic [ACC_W-1:0] mr [NUM_ACC];

   assign op     = fxmac_op_e'(opcode);
   assign x_op   = x_word[RF_W-1 -: OP_W];
   assign y_op   = y_word[RF_W-1 -: OP_W];
   assign is_mul = (op == OP_MUL) || (op == OP_MADD) || (op == OP_MSUB);

   fxmac_prod #(.OP_W(OP_W), .ACC_W(ACC_W)) prod_i (
      .x_op(x_op), .y_op(y_op), .x_signed(x_signed), .y_signed(y_signed),
      .frac_mode(frac_mode), .prod_o(prod)
   );

   always_comb begin
      mr_cur = '0;
      for (int i = 0; i < NUM_ACC; i++) begin
         if (acc_sel == SEL_W'(i)) mr_cur = mr[i];
      end
   end

   always_comb begin
      case (op)
         OP_MADD: acc_sum = mr_cur + prod;
         OP_MSUB: acc_sum = mr_cur - prod;
         OP_RND:  acc_sum = mr_cur;
         default: acc_sum = prod;
      endcase
   end

   assign rnd_en = frac_mode && (is_mul ? round_en : (op == OP_RND));

   fxmac_round #(.OP_W(OP_W), .ACC_W(ACC_W)) round_i (
      .val_i(acc_sum), .en_i(rnd_en), .val_o(rnd_val)
   );

   fxmac_sat #(.OP_W(OP_W), .ACC_W(ACC_W)) sat_i (
      .val_i(mr_cur), .signed_i(x_signed), .val_o(sat_val), .hit_o(sat_hit)
   );

   always_comb begin
      wr_en  = 1'b0;
      wr_val = rnd_val;
      case (op)
         OP_MUL, OP_MADD, OP_MSUB: wr_en = !to_rf;
         OP_RND: wr_en = 1'b1;
         OP_SAT: begin wr_en = 1'b1; wr_val = sat_val; end
         OP_CLR: begin wr_en = 1'b1; wr_val = '0; end
         default: wr_en = 1'b0;
      endcase
   end

   generate
      for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
         always_ff @(posedge clk) begin
            if (!rst_n) mr[g] <= '0;
            else if (wr_en && (acc_sel == SEL_W'(g))) mr[g] <= wr_val;
         end
         assign mr_q[g*ACC_W +: ACC_W] = mr[g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ovf <= 1'b0;
      else        ovf <= (op == OP_SAT) && sat_hit;
   end

   assign rf_word = frac_mode ? rnd_val[2*OP_W-1:OP_W] : rnd_val[OP_W-1:0];
   assign rf_we   = is_mul && to_rf;

   generate
      if (PAD_RF > 0) begin : g_rf_pad
         assign rf_wdata = {rf_word, {PAD_RF{1'b0}}};
      end else begin : g_rf_flat
         assign rf_wdata = rf_word;
      end
   endgenerate
endmodule

// File: rtl/fxmac_chk.sv
module fxmac_chk #(
   parameter int OP_W    = 32,
   parameter int ACC_W   = 80,
   parameter int NUM_ACC = 2,
   parameter int SEL_W   = 1
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [2:0]               opcode,
   input logic [SEL_W-1:0]         acc_sel,
   input logic                     to_rf,
   input logic                     x_signed,
   input logic                     rf_we,
   input logic                     ovf,
   input logic [NUM_ACC*ACC_W-1:0] mr_q
);
   localparam int W2 = 2*OP_W;

   // R7
   rfwe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |-> (to_rf && (opcode == 3'd1 || opcode == 3'd2 || opcode == 3'd3)));

   // R7
   rfwr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we |=> $stable(mr_q));

   // R11
   nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 3'd0 || opcode == 3'd7) |=> $stable(mr_q));

   // R9
   ovf_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> ($past(opcode) == 3'd5));

   generate
      for (genvar g = 0; g < NUM_ACC; g++) begin : g_reg
         // R10
         clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (opcode == 3'd6 && acc_sel == SEL_W'(g)) |=> (mr_q[g*ACC_W +: ACC_W] == '0));

         // R9
         sat_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (opcode == 3'd5 && x_signed && acc_sel == SEL_W'(g)) |=>
            ((&mr_q[g*ACC_W+W2-1 +: ACC_W-W2+1]) || !(|mr_q[g*ACC_W+W2-1 +: ACC_W-W2+1])));

         // R11
         unsel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (acc_sel != SEL_W'(g)) |=> $stable(mr_q[g*ACC_W +: ACC_W]));
      end
   endgenerate
endmodule

bind fxmac_unit fxmac_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .NUM_ACC(NUM_ACC), .SEL_W(SEL_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .opcode(opcode), .acc_sel(acc_sel), .to_rf(to_rf),
   .x_signed(x_signed), .rf_we(rf_we), .ovf(ovf), .mr_q(mr_q)
);

// File: tb/fxmac_unit_tb_top.sv
module fxmac_unit_tb_top;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   opcode = 3'd0;
   logic [39:0]  x_word = '0, y_word = '0;
   logic         x_signed = 0, y_signed = 0, frac_mode = 0, round_en = 0, to_rf = 0;
   logic [0:0]   acc_sel = 1'b0;
   logic         rf_we, ovf;
   logic [39:0]  rf_wdata;
   logic [159:0] mr_q;

   int total = 0;
   int bad = 0;
   logic [79:0] m_reg [2];
   logic        m_ovf;

   always #5 clk = ~clk;

   fxmac_unit dut_i (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .x_word(x_word), .y_word(y_word),
      .x_signed(x_signed), .y_signed(y_signed), .frac_mode(frac_mode),
      .round_en(round_en), .acc_sel(acc_sel), .to_rf(to_rf),
      .rf_we(rf_we), .rf_wdata(rf_wdata), .ovf(ovf), .mr_q(mr_q)
   );

   task automatic check(input string req, input logic [79:0] act, input logic [79:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [79:0] m_prod(logic [31:0] xv, logic [31:0] yv,
                                           logic xs, logic ys, logic fr);
      logic [127:0] a, b, p;
      a = xs ? {{96{xv[31]}}, xv} : {96'd0, xv};
      b = ys ? {{96{yv[31]}}, yv} : {96'd0, yv};
      p = a * b;
      if (fr && xs && ys) p = p << 1;
      return p[79:0];
   endfunction

   function automatic logic [79:0] m_round(logic [79:0] v);
      logic up;
      up = (v[31:0] > 32'h8000_0000) || (v[31:0] == 32'h8000_0000 && v[32]);
      return {v[79:32] + {47'd0, up}, 32'd0};
   endfunction

   function automatic logic [80:0] m_sat(logic [79:0] v, logic sg);
      logic [16:0] hi;
      hi = v[79:63];
      if (sg) begin
         if (hi != 17'd0 && hi != 17'h1FFFF)
            return {1'b1, v[79] ? {17'h1FFFF, 63'd0} : {17'd0, {63{1'b1}}}};
      end else begin
         if (v[79:64] != 16'd0)
            return {1'b1, v[79] ? 80'd0 : {16'd0, {64{1'b1}}}};
      end
      return {1'b0, v};
   endfunction

   function automatic string req_of(logic [2:0] op, logic rnd, logic torf);
      if (torf && op >= 3'd1 && op <= 3'd3) return "R7";
      if (rnd && op >= 3'd1 && op <= 3'd3) return "R6";
      case (op)
         3'd1: return "R3";
         3'd2, 3'd3: return "R5";
         3'd4: return "R8";
         3'd5: return "R9";
         3'd6: return "R10";
         default: return "R11";
      endcase
   endfunction

   // called at a falling edge; returns at the next falling edge
   task automatic do_op(input logic [2:0] op, input logic [39:0] xw, input logic [39:0] yw,
                        input logic xs, input logic ys, input logic fr, input logic rnd,
                        input logic sel, input logic torf, input string req);
      logic [79:0] v;
      logic [80:0] s;
      logic        mul;
      logic [79:0] nxt;
      logic        wr;
      logic        n_ovf;
      opcode = op; x_word = xw; y_word = yw; x_signed = xs; y_signed = ys;
      frac_mode = fr; round_en = rnd; acc_sel = sel; to_rf = torf;
      mul = (op == 3'd1) || (op == 3'd2) || (op == 3'd3);
      v = m_prod(xw[39:8], yw[39:8], xs, ys, fr);
      if (op == 3'd2) v = m_reg[sel] + v;
      if (op == 3'd3) v = m_reg[sel] - v;
      if (mul && rnd && fr) v = m_round(v);
      wr = 1'b0; nxt = m_reg[sel]; n_ovf = 1'b0;
      case (op)
         3'd1, 3'd2, 3'd3: begin wr = !torf; nxt = v; end
         3'd4: begin wr = 1'b1; nxt = fr ? m_round(m_reg[sel]) : m_reg[sel]; end
         3'd5: begin s = m_sat(m_reg[sel], xs); wr = 1'b1; nxt = s[79:0]; n_ovf = s[80]; end
         3'd6: begin wr = 1'b1; nxt = '0; end
         default: wr = 1'b0;
      endcase
      #2;
      check({req, " rf_we"}, {79'd0, rf_we}, {79'd0, mul && torf});
      if (mul && torf)
         check({req, " rf_wdata"}, {40'd0, rf_wdata},
               {40'd0, (fr ? v[63:32] : v[31:0]), 8'h00});
      @(posedge clk);
      if (wr) m_reg[sel] = nxt;
      m_ovf = n_ovf;
      @(negedge clk);
      check({req, " mr0"}, mr_q[79:0], m_reg[0]);
      check({req, " mr1"}, mr_q[159:80], m_reg[1]);
      check({req, " ovf"}, {79'd0, ovf}, {79'd0, m_ovf});
   endtask

   function automatic logic [39:0] pick(int k);
      logic [39:0] r;
      r = {$urandom, $urandom}[39:0];
      case (k % 6)
         0: r = {32'h8000_0000, r[7:0]};
         1: r = {32'hFFFF_FFFF, r[7:0]};
         2: r = {32'h7FFF_FFFF, r[7:0]};
         default: ;
      endcase
      return r;
   endfunction

   initial begin
      #1999995;
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_reg[0] = '0; m_reg[1] = '0; m_ovf = 1'b0;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 mr", {mr_q[79:0] | mr_q[159:80]}, 80'd0);
      check("R1 ovf", {79'd0, ovf}, 80'd0);
      check("R1 rf_we", {79'd0, rf_we}, 80'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release", {mr_q[79:0] | mr_q[159:80]}, 80'd0);

      // R2 / R3: low byte junk, unsigned all ones
      do_op(3'd1, 40'hFFFF_FFFF_A5, 40'hFFFF_FFFF_3C, 0, 0, 0, 0, 0, 0, "R2");
      check("R2 exact", mr_q[79:0], 80'h0000_FFFF_FFFE_0000_0001);
      do_op(3'd1, 40'hFFFF_FFFD_FF, 40'h0000_0005_11, 1, 1, 0, 0, 1, 0, "R3");
      check("R3 signed", mr_q[159:80], {80{1'b1}} - 80'd14);
      do_op(3'd1, 40'hFFFF_FFFF_00, 40'h0000_0002_00, 1, 0, 0, 0, 0, 0, "R3");
      do_op(3'd1, 40'hFFFF_FFFF_00, 40'h0000_0002_00, 0, 1, 0, 0, 0, 0, "R3");
      // R4: fractional shift only for signed x signed
      do_op(3'd1, 40'h4000_0000_00, 40'h4000_0000_00, 1, 1, 1, 0, 0, 0, "R4");
      check("R4 half*half", mr_q[79:0], 80'h0000_2000_0000_0000_0000);
      do_op(3'd1, 40'h4000_0000_00, 40'h4000_0000_00, 0, 1, 1, 0, 1, 0, "R4");
      check("R4 no shift", mr_q[159:80], 80'h0000_1000_0000_0000_0000);
      // R5
      do_op(3'd2, 40'h0000_0003_00, 40'h0000_0007_00, 0, 0, 0, 0, 0, 0, "R5");
      do_op(3'd3, 40'h0000_0003_00, 40'h0000_0007_00, 1, 1, 0, 0, 1, 0, "R5");
      do_op(3'd6, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0, "R10");
      do_op(3'd3, 40'h0000_0001_00, 40'h0000_0001_00, 0, 0, 0, 0, 0, 0, "R5");
      check("R5 wrap", mr_q[79:0], {80{1'b1}});
      // R6 / R8: ties
      do_op(3'd1, 40'h8000_0000_00, 40'h0000_0001_00, 0, 0, 0, 0, 0, 0, "R8");
      do_op(3'd4, 40'h0, 40'h0, 0, 0, 1, 0, 0, 0, "R8");
      check("R8 tie even", mr_q[79:0], 80'd0);
      do_op(3'd1, 40'h8000_0000_00, 40'h0000_0003_00, 0, 0, 0, 0, 0, 0, "R8");
      do_op(3'd4, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0, "R8");
      do_op(3'd4, 40'h0, 40'h0, 0, 0, 1, 0, 0, 0, "R8");
      check("R8 tie odd", mr_q[79:0], 80'h0000_0000_0002_0000_0000);
      do_op(3'd1, 40'h4000_0001_00, 40'h4000_0001_00, 1, 1, 1, 1, 1, 0, "R6");
      do_op(3'd1, 40'h8000_0000_00, 40'h0000_0003_00, 0, 0, 0, 1, 1, 0, "R6");
      // R7
      do_op(3'd1, 40'h4000_0001_00, 40'h4000_0001_00, 1, 1, 1, 1, 0, 1, "R7");
      do_op(3'd2, 40'h1234_5678_00, 40'h0000_0010_00, 0, 0, 0, 0, 1, 1, "R7");
      // R9
      do_op(3'd1, 40'h8000_0000_00, 40'h8000_0000_00, 1, 1, 1, 0, 0, 0, "R9");
      do_op(3'd5, 40'h0, 40'h0, 1, 0, 0, 0, 0, 0, "R9");
      check("R9 pos clamp", mr_q[79:0], 80'h0000_7FFF_FFFF_FFFF_FFFF);
      do_op(3'd5, 40'h0, 40'h0, 1, 0, 0, 0, 0, 0, "R9");
      do_op(3'd6, 40'h0, 40'h0, 0, 0, 0, 0, 1, 0, "R10");
      for (int i = 0; i < 4; i++)
         do_op(3'd2, 40'hFFFF_FFFF_00, 40'hFFFF_FFFF_00, 0, 0, 0, 0, 1, 0, "R9");
      do_op(3'd5, 40'h0, 40'h0, 0, 0, 0, 0, 1, 0, "R9");
      check("R9 unsigned max", mr_q[159:80], 80'h0000_FFFF_FFFF_FFFF_FFFF);
      do_op(3'd3, 40'h0000_0100_00, 40'h0000_0100_00, 0, 0, 0, 0, 1, 0, "R9");
      do_op(3'd5, 40'h0, 40'h0, 0, 0, 0, 0, 1, 0, "R9");
      do_op(3'd3, 40'h7FFF_FFFF_00, 40'h7FFF_FFFF_00, 1, 1, 0, 0, 0, 0, "R9");
      do_op(3'd3, 40'h7FFF_FFFF_00, 40'h7FFF_FFFF_00, 1, 1, 0, 0, 0, 0, "R9");
      do_op(3'd3, 40'h7FFF_FFFF_00, 40'h7FFF_FFFF_00, 1, 1, 0, 0, 0, 0, "R9");
      do_op(3'd5, 40'h0, 40'h0, 1, 0, 0, 0, 0, 0, "R9");
      // R10 / R11
      do_op(3'd6, 40'h0, 40'h0, 0, 0, 0, 0, 0, 0, "R10");
      do_op(3'd0, 40'hFFFF_FFFF_FF, 40'hFFFF_FFFF_FF, 1, 1, 1, 1, 1, 0, "R11");
      do_op(3'd7, 40'hFFFF_FFFF_FF, 40'hFFFF_FFFF_FF, 1, 1, 1, 1, 1, 1, "R11");

      for (int n = 0; n < 600; n++) begin
         logic [2:0]  rop;
         logic [39:0] rx, ry;
         logic [7:0]  fl;
         rop = 3'($urandom % 8);
         rx = pick(n);
         ry = pick(n / 6);
         fl = 8'($urandom);
         do_op(rop, rx, ry, fl[0], fl[1], fl[2], fl[3], fl[4], fl[5] & fl[6],
               req_of(rop, fl[3], fl[5] & fl[6]));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule